// File: doc/BRIEF.md
# Two-Level Address Translation Buffer

This block translates virtual addresses for an instruction-fetch port and a data-access port. Each port has its own single-entry first-level register, which holds the most recent translation that port completed. A request whose page number and address-space identifier match that register is answered in the same cycle. When the first-level register misses, a shared 16-entry second level is searched. The entries are arranged as 4 rows of 4 ways, and one row is compared per cycle under a small up-counter. A match refills the requesting port's first-level register, and the request is then answered from it. If no row matches, the port receives a one-cycle miss exception.

Translation starts out off. While it is off, addresses pass straight through. A trap turns translation off. A jump-to-virtual-address command turns it on and emits a one-cycle redirect to the requested address. Privileged software loads second-level entries with an indexed write, which uses a given slot, or a random write, which uses a slot picked by a free-running counter. Any write flushes both first-level registers. A requester holds its request and its address stable until it sees an acknowledge or a miss.

Top module: `tlb2_mmu`

## Requirements
- R1: After reset, translation is off, no redirect is pending, and every first- and second-level entry is invalid, so the first lookup after enabling ends in a miss.
- R2: While translation is off, a request is acknowledged in the same cycle, the physical address equals the virtual address, and no miss is raised.
- R3: A jump command without a trap turns translation on from the next cycle. In that cycle the redirect output pulses for exactly one cycle and carries the jump address.
- R4: A trap turns translation off from the next cycle, even when a jump arrives in the same cycle, and it abandons any search in progress.
- R5: When translation is on and a port's first-level register matches both the page number (virtual address bits 31:12) and the current ASID, the request is acknowledged in the same cycle. The physical address is the stored frame number followed by virtual address bits 11:0.
- R6: On a first-level miss, the second level is searched one row per cycle, starting at row 0. Entry index i lies in row i[3:2] and way i[1:0]. A hit in row r acknowledges the request r+3 cycles after the request is first presented.
- R7: When no row matches, the port's miss output pulses 5 cycles after the request is first presented, and no acknowledge is given.
- R8: An entry whose ASID differs from the current ASID does not match, even when its page number does.
- R9: An indexed write stores page, ASID and frame at the given index. A random write stores them at a slot that a later lookup finds. Either write invalidates both first-level registers, so the next lookup of a page that was cached pays the search latency again.
- R10: When both ports miss in the same cycle, the instruction port is searched first. The data search starts only after the instruction refill completes.
- R11: The two first-level registers are independent: both ports can hit on different pages in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| asid_i | input | 8 | Current address-space identifier |
| trap_i | input | 1 | Trap taken; turns translation off |
| jrv_i | input | 1 | Jump-to-virtual-address command |
| jrv_addr_i | input | 32 | Target of the jump command |
| xlate_en_o | output | 1 | Translation is on |
| redirect_o | output | 1 | One-cycle redirect pulse |
| redirect_addr_o | output | 32 | Redirect target |
| ireq_i | input | 1 | Instruction translation request |
| ivaddr_i | input | 32 | Instruction virtual address |
| iack_o | output | 1 | Instruction translation valid |
| ipaddr_o | output | 32 | Instruction physical address |
| imiss_o | output | 1 | Instruction miss exception pulse |
| dreq_i | input | 1 | Data translation request |
| dvaddr_i | input | 32 | Data virtual address |
| dack_o | output | 1 | Data translation valid |
| dpaddr_o | output | 32 | Data physical address |
| dmiss_o | output | 1 | Data miss exception pulse |
| wr_indexed_i | input | 1 | Write entry at wr_index_i |
| wr_random_i | input | 1 | Write entry at the random slot |
| wr_index_i | input | 4 | Index for indexed writes |
| wr_vpn_i | input | 20 | Page number to store |
| wr_asid_i | input | 8 | ASID to store |
| wr_pfn_i | input | 20 | Frame number to store |

## Verification
Lookups are aimed at entries in row 0, row 1 and row 3, so the measured latencies of 3, 4 and 6 cycles show that the search runs row by row. A page that is absent and a page present under another ASID are both looked up, and both must end in a miss at cycle 5; this separates a missing tag from a tag that fails only the ASID compare. Two ports that miss together show the arbitration order, and two ports that hit together show that their first-level registers are independent. Lookups repeated just after a write show the flush. Trap and jump stimuli, alone and in the same cycle, settle which of the two wins.

// File: rtl/tlb2_pkg.sv
package tlb2_pkg;
  typedef enum logic [1:0] {
    WK_IDLE,
    WK_SCAN,
    WK_FILL,
    WK_MISS
  } walk_state_e;

  typedef enum logic {
    SRC_INSN = 1'b0,
    SRC_DATA = 1'b1
  } walk_src_e;
endpackage

// File: rtl/tlb2_l1_entry.sv
module tlb2_l1_entry #(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              load_i,
  input  logic [VPN_W-1:0]  load_vpn_i,
  input  logic [ASID_W-1:0] load_asid_i,
  input  logic [PFN_W-1:0]  load_pfn_i,
  input  logic [VPN_W-1:0]  look_vpn_i,
  input  logic [ASID_W-1:0] look_asid_i,
  output logic              hit_o,
  output logic [PFN_W-1:0]  pfn_o
);
  logic              valid_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ASID_W-1:0] asid_q;
  logic [PFN_W-1:0]  pfn_q;

  // flush wins over a refill in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vpn_q   <= '0;
      asid_q  <= '0;
      pfn_q   <= '0;
    end else if (flush_i) begin
      valid_q <= 1'b0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      vpn_q   <= load_vpn_i;
      asid_q  <= load_asid_i;
      pfn_q   <= load_pfn_i;
    end
  end

  assign hit_o = valid_q && (vpn_q == look_vpn_i) && (asid_q == look_asid_i);
  assign pfn_o = pfn_q;
endmodule

// File: rtl/tlb2_l2_array.sv
module tlb2_l2_array #(
  parameter int ROWS   = 4,
  parameter int WAYS   = 4,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20,
  localparam int ENTRIES = ROWS * WAYS,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int ROW_W   = $clog2(ROWS),
  localparam int WAY_W   = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [PFN_W-1:0]  wr_pfn_i,
  input  logic [ROW_W-1:0]  row_sel_i,
  input  logic [VPN_W-1:0]  cmp_vpn_i,
  input  logic [ASID_W-1:0] cmp_asid_i,
  output logic              row_hit_o,
  output logic [WAY_W-1:0]  hit_way_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [VPN_W-1:0]  rd_vpn_o,
  output logic [ASID_W-1:0] rd_asid_o,
  output logic [PFN_W-1:0]  rd_pfn_o
);
  localparam int LINE_W = VPN_W + ASID_W + PFN_W;

  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [WAYS-1:0]    way_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  // line layout: {vpn, asid, pfn}
  always_ff @(posedge clk_i) begin
    if (wr_en_i) line_q[wr_idx_i] <= {wr_vpn_i, wr_asid_i, wr_pfn_i};
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic [WAY_W-1:0] WSEL = WAY_W'(w);
    logic [IDX_W-1:0]  idx;
    logic [LINE_W-1:0] line;
    assign idx        = {row_sel_i, WSEL};
    assign line       = line_q[idx];
    assign way_hit[w] = valid_q[idx]
                     && (line[LINE_W-1 -: VPN_W] == cmp_vpn_i)
                     && (line[PFN_W +: ASID_W] == cmp_asid_i);
  end

  // lowest way wins on duplicates
  always_comb begin
    hit_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) hit_way_o = WAY_W'(w);
    end
  end
  assign row_hit_o = |way_hit;

  logic [LINE_W-1:0] rd_line;
  assign rd_line   = line_q[rd_idx_i];
  assign rd_vpn_o  = rd_line[LINE_W-1 -: VPN_W];
  assign rd_asid_o = rd_line[PFN_W +: ASID_W];
  assign rd_pfn_o  = rd_line[PFN_W-1:0];
endmodule

// File: rtl/tlb2_walker.sv
module tlb2_walker
  import tlb2_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int WAYS = 4,
  localparam int ROW_W = $clog2(ROWS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int CNT_W = ROW_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   abort_i,
  input  logic                   imiss_i,
  input  logic                   dmiss_i,
  input  logic                   row_hit_i,
  input  logic [WAY_W-1:0]       hit_way_i,
  output walk_src_e              src_o,
  output logic [ROW_W-1:0]       row_o,
  output logic                   fill_o,
  output logic [ROW_W+WAY_W-1:0] fill_idx_o,
  output logic                   ifault_o,
  output logic                   dfault_o
);
  walk_state_e             state_q;
  walk_src_e               src_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [ROW_W+WAY_W-1:0]  idx_q;
  logic                    last_row;

  assign last_row = (cnt_q[ROW_W-1:0] == ROW_W'(ROWS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WK_IDLE;
      src_q   <= SRC_INSN;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else if (abort_i) begin
      state_q <= WK_IDLE;
    end else begin
      unique case (state_q)
        WK_IDLE: begin
          cnt_q <= '0;
          if (imiss_i) begin
            src_q   <= SRC_INSN;
            state_q <= WK_SCAN;
          end else if (dmiss_i) begin
            src_q   <= SRC_DATA;
            state_q <= WK_SCAN;
          end
        end
        WK_SCAN: begin
          if (row_hit_i) begin
            idx_q   <= {cnt_q[ROW_W-1:0], hit_way_i};
            state_q <= WK_FILL;
          end else if (last_row) begin
            state_q <= WK_MISS;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        WK_FILL: state_q <= WK_IDLE;
        WK_MISS: state_q <= WK_IDLE;
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  assign src_o      = src_q;
  assign row_o      = cnt_q[ROW_W-1:0];
  assign fill_o     = (state_q == WK_FILL) && !abort_i;
  assign fill_idx_o = idx_q;
  assign ifault_o   = (state_q == WK_MISS) && !abort_i && (src_q == SRC_INSN);
  assign dfault_o   = (state_q == WK_MISS) && !abort_i && (src_q == SRC_DATA);
endmodule

// File: rtl/tlb2_mmu.sv
module tlb2_mmu
  import tlb2_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  parameter int ROWS   = 4,
  parameter int WAYS   = 4,
  localparam int VPN_W = VA_W - PAGE_W,
  localparam int PA_W  = PFN_W + PAGE_W,
  localparam int IDX_W = $clog2(ROWS * WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              trap_i,
  input  logic              jrv_i,
  input  logic [VA_W-1:0]   jrv_addr_i,
  output logic              xlate_en_o,
  output logic              redirect_o,
  output logic [VA_W-1:0]   redirect_addr_o,
  input  logic              ireq_i,
  input  logic [VA_W-1:0]   ivaddr_i,
  output logic              iack_o,
  output logic [PA_W-1:0]   ipaddr_o,
  output logic              imiss_o,
  input  logic              dreq_i,
  input  logic [VA_W-1:0]   dvaddr_i,
  output logic              dack_o,
  output logic [PA_W-1:0]   dpaddr_o,
  output logic              dmiss_o,
  input  logic              wr_indexed_i,
  input  logic              wr_random_i,
  input  logic [IDX_W-1:0]  wr_index_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [PFN_W-1:0]  wr_pfn_i
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int NPORT = 2;

  logic              en_q, redir_q;
  logic [VA_W-1:0]   redir_addr_q;
  logic [IDX_W-1:0]  rnd_q;
  logic              wr_any, abort;
  logic [IDX_W-1:0]  wr_idx;

  // trap has priority over jump
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q         <= 1'b0;
      redir_q      <= 1'b0;
      redir_addr_q <= '0;
      rnd_q        <= '0;
    end else begin
      rnd_q   <= rnd_q + 1'b1;
      redir_q <= jrv_i && !trap_i;
      if (jrv_i && !trap_i) redir_addr_q <= jrv_addr_i;
      if (trap_i)     en_q <= 1'b0;
      else if (jrv_i) en_q <= 1'b1;
    end
  end

  assign xlate_en_o      = en_q;
  assign redirect_o      = redir_q;
  assign redirect_addr_o = redir_addr_q;

  assign wr_any = wr_indexed_i || wr_random_i;
  assign wr_idx = wr_indexed_i ? wr_index_i : rnd_q;
  assign abort  = trap_i || wr_any;

  // walker / second-level wiring
  walk_src_e               src;
  logic [ROW_W-1:0]        row;
  logic                    fill;
  logic [IDX_W-1:0]        fill_idx;
  logic                    row_hit;
  logic [WAY_W-1:0]        hit_way;
  logic [VPN_W-1:0]        rd_vpn;
  logic [ASID_W-1:0]       rd_asid;
  logic [PFN_W-1:0]        rd_pfn;
  logic [VA_W-1:0]         search_va;
  logic                    ifault, dfault;

  logic [VA_W-1:0]  vaddr_a [NPORT];
  logic             req_a   [NPORT];
  logic             hit_a   [NPORT];
  logic [PFN_W-1:0] pfn_a   [NPORT];
  logic             load_a  [NPORT];
  logic             miss_a  [NPORT];
  logic             ack_a   [NPORT];
  logic [PA_W-1:0]  pa_a    [NPORT];

  assign vaddr_a[0] = ivaddr_i;
  assign vaddr_a[1] = dvaddr_i;
  assign req_a[0]   = ireq_i;
  assign req_a[1]   = dreq_i;
  assign load_a[0]  = fill && (src == SRC_INSN);
  assign load_a[1]  = fill && (src == SRC_DATA);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    tlb2_l1_entry #(
      .VPN_W (VPN_W),
      .ASID_W(ASID_W),
      .PFN_W (PFN_W)
    ) u_l1 (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (wr_any),
      .load_i     (load_a[p]),
      .load_vpn_i (rd_vpn),
      .load_asid_i(rd_asid),
      .load_pfn_i (rd_pfn),
      .look_vpn_i (vaddr_a[p][VA_W-1:PAGE_W]),
      .look_asid_i(asid_i),
      .hit_o      (hit_a[p]),
      .pfn_o      (pfn_a[p])
    );
    assign miss_a[p] = req_a[p] && en_q && !hit_a[p];
    assign ack_a[p]  = req_a[p] && (!en_q || hit_a[p]);
    assign pa_a[p]   = en_q ? {pfn_a[p], vaddr_a[p][PAGE_W-1:0]} : PA_W'(vaddr_a[p]);
  end

  assign search_va = (src == SRC_DATA) ? dvaddr_i : ivaddr_i;

  tlb2_walker #(
    .ROWS(ROWS),
    .WAYS(WAYS)
  ) u_walker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .abort_i   (abort),
    .imiss_i   (miss_a[0]),
    .dmiss_i   (miss_a[1]),
    .row_hit_i (row_hit),
    .hit_way_i (hit_way),
    .src_o     (src),
    .row_o     (row),
    .fill_o    (fill),
    .fill_idx_o(fill_idx),
    .ifault_o  (ifault),
    .dfault_o  (dfault)
  );

  tlb2_l2_array #(
    .ROWS  (ROWS),
    .WAYS  (WAYS),
    .VPN_W (VPN_W),
    .ASID_W(ASID_W),
    .PFN_W (PFN_W)
  ) u_l2 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_any),
    .wr_idx_i  (wr_idx),
    .wr_vpn_i  (wr_vpn_i),
    .wr_asid_i (wr_asid_i),
    .wr_pfn_i  (wr_pfn_i),
    .row_sel_i (row),
    .cmp_vpn_i (search_va[VA_W-1:PAGE_W]),
    .cmp_asid_i(asid_i),
    .row_hit_o (row_hit),
    .hit_way_o (hit_way),
    .rd_idx_i  (fill_idx),
    .rd_vpn_o  (rd_vpn),
    .rd_asid_o (rd_asid),
    .rd_pfn_o  (rd_pfn)
  );

  assign iack_o   = ack_a[0];
  assign dack_o   = ack_a[1];
  assign ipaddr_o = pa_a[0];
  assign dpaddr_o = pa_a[1];
  assign imiss_o  = ifault;
  assign dmiss_o  = dfault;
endmodule

// File: rtl/tlb2_mmu_chk.sv
module tlb2_mmu_chk #(
  parameter int VA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int PA_W   = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            trap_i,
  input logic            jrv_i,
  input logic [VA_W-1:0] jrv_addr_i,
  input logic            xlate_en_o,
  input logic            redirect_o,
  input logic [VA_W-1:0] redirect_addr_o,
  input logic            ireq_i,
  input logic [VA_W-1:0] ivaddr_i,
  input logic            iack_o,
  input logic [PA_W-1:0] ipaddr_o,
  input logic            imiss_o,
  input logic            dmiss_o,
  input logic            dack_o,
  input logic            wr_indexed_i,
  input logic            wr_random_i
);
  a_r4_trap_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> !xlate_en_o);

  a_r3_jump_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jrv_i && !trap_i) |=> (xlate_en_o && redirect_o && redirect_addr_o == $past(jrv_addr_i)));

  a_r2_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xlate_en_o && ireq_i) |-> (iack_o && ipaddr_o == PA_W'(ivaddr_i) && !imiss_o));

  a_r7_miss_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imiss_o |-> !iack_o) and (dmiss_o |-> !dack_o));

  a_r10_single_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({imiss_o, dmiss_o}));

  a_r9_write_flushes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_indexed_i || wr_random_i) && xlate_en_o) |=> (!xlate_en_o || (!iack_o && !dack_o)));

  a_r5_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_o |-> (ipaddr_o[PAGE_W-1:0] == ivaddr_i[PAGE_W-1:0]));
endmodule

bind tlb2_mmu tlb2_mmu_chk #(
  .VA_W  (VA_W),
  .PAGE_W(PAGE_W),
  .PA_W  (PA_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .trap_i         (trap_i),
  .jrv_i          (jrv_i),
  .jrv_addr_i     (jrv_addr_i),
  .xlate_en_o     (xlate_en_o),
  .redirect_o     (redirect_o),
  .redirect_addr_o(redirect_addr_o),
  .ireq_i         (ireq_i),
  .ivaddr_i       (ivaddr_i),
  .iack_o         (iack_o),
  .ipaddr_o       (ipaddr_o),
  .imiss_o        (imiss_o),
  .dmiss_o        (dmiss_o),
  .dack_o         (dack_o),
  .wr_indexed_i   (wr_indexed_i),
  .wr_random_i    (wr_random_i)
);

// File: tb/tlb2_mmu_tb.sv
module tlb2_mmu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  asid_i = '0;
  logic        trap_i = 1'b0;
  logic        jrv_i = 1'b0;
  logic [31:0] jrv_addr_i = '0;
  logic        xlate_en_o, redirect_o;
  logic [31:0] redirect_addr_o;
  logic        ireq_i = 1'b0;
  logic [31:0] ivaddr_i = '0;
  logic        iack_o, imiss_o;
  logic [31:0] ipaddr_o;
  logic        dreq_i = 1'b0;
  logic [31:0] dvaddr_i = '0;
  logic        dack_o, dmiss_o;
  logic [31:0] dpaddr_o;
  logic        wr_indexed_i = 1'b0, wr_random_i = 1'b0;
  logic [3:0]  wr_index_i = '0;
  logic [19:0] wr_vpn_i = '0, wr_pfn_i = '0;
  logic [7:0]  wr_asid_i = '0;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  localparam logic [19:0] VPN_A = 20'h12345, PFN_A = 20'hABCDE;
  localparam logic [19:0] VPN_B = 20'h0F00D, PFN_B = 20'h11111;
  localparam logic [19:0] VPN_C = 20'h00042, PFN_C = 20'h22222;
  localparam logic [19:0] VPN_D = 20'h77777, PFN_D = 20'h33333;
  localparam logic [19:0] VPN_E = 20'h55555;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  tlb2_mmu dut_i (
    .clk_i, .rst_ni, .asid_i, .trap_i, .jrv_i, .jrv_addr_i,
    .xlate_en_o, .redirect_o, .redirect_addr_o,
    .ireq_i, .ivaddr_i, .iack_o, .ipaddr_o, .imiss_o,
    .dreq_i, .dvaddr_i, .dack_o, .dpaddr_o, .dmiss_o,
    .wr_indexed_i, .wr_random_i, .wr_index_i, .wr_vpn_i, .wr_asid_i, .wr_pfn_i
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // waits on one port; latency counted in cycles from the request
  task automatic wait_port(input bit dport, input int maxc, output int lat,
                           output bit got_ack, output bit got_miss, output logic [31:0] pa);
    got_ack = 0; got_miss = 0; lat = -1; pa = '0;
    for (int k = 0; k <= maxc; k++) begin
      #1;
      if (dport ? dack_o : iack_o) begin
        got_ack = 1; lat = k; pa = dport ? dpaddr_o : ipaddr_o; break;
      end
      if (dport ? dmiss_o : imiss_o) begin
        got_miss = 1; lat = k; break;
      end
      @(negedge clk_i);
    end
  endtask

  task automatic lookup(input bit dport, input logic [31:0] va, input int exp_lat,
                        input bit exp_hit, input logic [31:0] exp_pa, input string req);
    int lat; bit a, m; logic [31:0] pa;
    @(negedge clk_i);
    if (dport) begin dreq_i = 1; dvaddr_i = va; end
    else       begin ireq_i = 1; ivaddr_i = va; end
    wait_port(dport, 12, lat, a, m, pa);
    ireq_i = 0; dreq_i = 0;
    check(lat == exp_lat, {req, " latency"}, 64'(lat), 64'(exp_lat));
    check(exp_hit ? a : m, {req, " outcome"}, {62'd0, a, m}, exp_hit ? 64'd2 : 64'd1);
    if (exp_hit) check(pa == exp_pa, {req, " paddr"}, 64'(pa), 64'(exp_pa));
  endtask

  task automatic write_entry(input bit rnd, input logic [3:0] idx, input logic [19:0] vpn,
                             input logic [7:0] asid, input logic [19:0] pfn);
    @(negedge clk_i);
    wr_indexed_i = !rnd; wr_random_i = rnd; wr_index_i = idx;
    wr_vpn_i = vpn; wr_asid_i = asid; wr_pfn_i = pfn;
    @(negedge clk_i);
    wr_indexed_i = 0; wr_random_i = 0;
  endtask

  task automatic t_reset();
    #1;
    check(xlate_en_o == 0, "R1 xlate off after reset", 64'(xlate_en_o), 0);
    check(redirect_o == 0, "R1 no redirect after reset", 64'(redirect_o), 0);
  endtask

  task automatic t_passthrough();
    lookup(0, 32'hDEAD_BEEF, 0, 1, 32'hDEAD_BEEF, "R2 insn passthrough");
    lookup(1, 32'h0000_1234, 0, 1, 32'h0000_1234, "R2 data passthrough");
  endtask

  task automatic t_enable();
    @(negedge clk_i);
    jrv_i = 1; jrv_addr_i = 32'h8000_0040;
    @(negedge clk_i);
    jrv_i = 0;
    check(xlate_en_o == 1, "R3 enabled after jump", 64'(xlate_en_o), 1);
    check(redirect_o == 1 && redirect_addr_o == 32'h8000_0040, "R3 redirect pulse",
          {31'd0, redirect_o, redirect_addr_o}, {31'd0, 1'b1, 32'h8000_0040});
    @(negedge clk_i);
    check(redirect_o == 0, "R3 redirect one cycle", 64'(redirect_o), 0);
  endtask

  task automatic t_empty();
    asid_i = 8'd5;
    lookup(0, {VPN_A, 12'h010}, 5, 0, '0, "R1 empty second level misses");
  endtask

  task automatic t_rows();
    write_entry(0, 4'd1,  VPN_A, 8'd5, PFN_A);
    write_entry(0, 4'd14, VPN_B, 8'd5, PFN_B);
    write_entry(0, 4'd6,  VPN_C, 8'd7, PFN_C);
    lookup(0, {VPN_A, 12'h3C4}, 3, 1, {PFN_A, 12'h3C4}, "R6 row0 search");
    lookup(0, {VPN_A, 12'hFFF}, 0, 1, {PFN_A, 12'hFFF}, "R5 first-level hit");
    lookup(1, {VPN_B, 12'h008}, 6, 1, {PFN_B, 12'h008}, "R6 row3 search");
    lookup(1, {VPN_E, 12'h000}, 5, 0, '0, "R7 absent page miss");
  endtask

  task automatic t_asid();
    lookup(1, {VPN_C, 12'h100}, 5, 0, '0, "R8 asid mismatch misses");
    asid_i = 8'd7;
    lookup(1, {VPN_C, 12'h100}, 4, 1, {PFN_C, 12'h100}, "R8 asid match row1");
    asid_i = 8'd5;
  endtask

  task automatic t_priority();
    int li = -1, ld = -1;
    write_entry(0, 4'd6, VPN_C, 8'd7, PFN_C); // flushes both first-level regs
    @(negedge clk_i);
    ireq_i = 1; ivaddr_i = {VPN_A, 12'h020};
    dreq_i = 1; dvaddr_i = {VPN_B, 12'h030};
    for (int k = 0; k <= 15; k++) begin
      #1;
      if (li < 0 && iack_o) begin li = k; ireq_i = 0; end
      if (ld < 0 && dack_o) begin ld = k; dreq_i = 0; end
      if (li >= 0 && ld >= 0) break;
      @(negedge clk_i);
    end
    ireq_i = 0; dreq_i = 0;
    check(li == 3, "R9 flush forces re-search", 64'(li), 3);
    check(ld == 9, "R10 data served after insn", 64'(ld), 9);
  endtask

  task automatic t_dual_hit();
    @(negedge clk_i);
    ireq_i = 1; ivaddr_i = {VPN_A, 12'h444};
    dreq_i = 1; dvaddr_i = {VPN_B, 12'h555};
    #1;
    check(iack_o && dack_o, "R11 both ports hit", {62'd0, iack_o, dack_o}, 3);
    check(ipaddr_o == {PFN_A, 12'h444} && dpaddr_o == {PFN_B, 12'h555}, "R11 both paddrs",
          {ipaddr_o, dpaddr_o}, {PFN_A, 12'h444, PFN_B, 12'h555});
    @(negedge clk_i);
    ireq_i = 0; dreq_i = 0;
  endtask

  task automatic t_random();
    int lat; bit a, m; logic [31:0] pa;
    write_entry(1, 4'd0, VPN_D, 8'd5, PFN_D);
    @(negedge clk_i);
    ireq_i = 1; ivaddr_i = {VPN_D, 12'h0AB};
    wait_port(0, 12, lat, a, m, pa);
    ireq_i = 0;
    check(a && pa == {PFN_D, 12'h0AB}, "R9 random write found", 64'(pa), {32'd0, PFN_D, 12'h0AB});
    check(lat >= 3 && lat <= 6, "R9 random write latency", 64'(lat), 3);
  endtask

  task automatic t_trap();
    int lat; bit a, m; logic [31:0] pa;
    write_entry(0, 4'd1, VPN_A, 8'd5, PFN_A); // flush, next lookup walks
    @(negedge clk_i);
    ireq_i = 1; ivaddr_i = {VPN_A, 12'h001};
    @(negedge clk_i);
    trap_i = 1;
    @(negedge clk_i);
    trap_i = 0;
    #1;
    check(xlate_en_o == 0, "R4 trap disables", 64'(xlate_en_o), 0);
    check(iack_o && ipaddr_o == {VPN_A, 12'h001}, "R4 walk abandoned, passthrough",
          64'(ipaddr_o), {32'd0, VPN_A, 12'h001});
    ireq_i = 0;
    @(negedge clk_i);
    trap_i = 1; jrv_i = 1; jrv_addr_i = 32'h1000_0000;
    @(negedge clk_i);
    trap_i = 0; jrv_i = 0;
    #1;
    check(xlate_en_o == 0 && redirect_o == 0, "R4 trap beats jump",
          {62'd0, xlate_en_o, redirect_o}, 0);
    lookup(0, 32'h0BAD_0000, 0, 1, 32'h0BAD_0000, "R4 passthrough after trap");
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 20000) begin
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_passthrough();
    t_enable();
    t_empty();
    t_rows();
    t_asid();
    t_priority();
    t_dual_hit();
    t_random();
    t_trap();
    repeat (2) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule